// File: doc/BRIEF.md
# Event Performance Counter Unit

This block is a small performance monitor with three 32-bit counters. A cycle counter counts clock cycles, optionally divided by 64. Two event counters each count one event, chosen by an 8-bit code. Events arrive as a vector of single-cycle pulse inputs, indexed by event code. A single control word holds the global run bit, the counter reset strobes, the cycle divider select, three interrupt enables, three sticky overflow flags and the two event selects.

Software reaches the control word and all three counters through a register port with a 2-bit address. Writes take effect on the clock edge. Reads are combinational and return the live value. No counter has an enable of its own. Software parks an event counter by selecting code 0x20, whose source is tied inactive here. The overflow flags share one interrupt line. Software clears a flag by writing a one to it, so writing back a word just read has no side effect except to clear the flags it found set.

Top module: `evt_perf_unit`

## Requirements
- R1: After reset the control word, all three counters and `irq_o` are zero.
- R2: Control bit 0 is the global run bit. While it is 0, no counter changes except through a software write or a reset strobe.
- R3: When the run bit is 1 and control bit 3 is 0, the cycle counter advances by one on every clock edge.
- R4: When control bit 3 is 1, the cycle counter advances once every 64 run cycles. A cycle-counter reset strobe restarts the divide-by-64 phase.
- R5: Event counter 0 takes its code from control bits 27:20, and event counter 1 takes its code from bits 19:12. A counter advances on each edge where the run bit is 1 and `evt_i[code]` is 1.
- R6: Code 0x20 never counts, even when `evt_i[32]` is high. Codes at or above the vector width also never count.
- R7: Writing a control word with bit 1 set clears both event counters. Writing one with bit 2 set clears the cycle counter. Bits 1 and 2 always read back as 0.
- R8: Address 1 is the cycle counter, address 2 is event counter 0 and address 3 is event counter 1. A write to a counter loads it, and the write wins over an increment in the same cycle. A read returns the live value.
- R9: Each counter wraps from 0xFFFFFFFF to 0. On the wrap it sets its sticky flag: bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R10: Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. A wrap in the same cycle as the clear leaves the flag set.
- R11: `irq_o` is high while any flag is set together with its enable: bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R12: Address 0 is the control word. Bits 7 and 31:28 ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | EVT_NUM | Event pulses, bit n carries code n |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Live read data for the selected register |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The assertions assume three things about the inputs: the register port carries at most one write per cycle, the event vector holds valid levels, and reset is released away from a clock edge. The bench drives every input one time unit after the rising edge, so each write and each event pulse is seen at exactly one known edge. Every counting window is opened and closed by a control write, so the expected counts are exact. Event pulses are only raised while the addressed counter is not being written, except in the one case that tests write priority.

// File: rtl/evt_perf_pkg.sv
package evt_perf_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_CNT  = 3;
    localparam int SEL_W    = 8;
    // counter slots: flag bit = B_OVF + slot, enable bit = B_IEN + slot
    localparam int IX_E0    = 0;
    localparam int IX_E1    = 1;
    localparam int IX_CYC   = 2;
    // control word bit positions
    localparam int B_RUN     = 0;
    localparam int B_RST_EVT = 1;
    localparam int B_RST_CYC = 2;
    localparam int B_DIV     = 3;
    localparam int B_IEN     = 4;
    localparam int B_OVF     = 8;
    localparam int B_SEL1    = 12;
    localparam int B_SEL0    = 20;

    typedef logic [REG_W-1:0] reg_w_t;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CYC  = 2'd1,
        ADDR_E0   = 2'd2,
        ADDR_E1   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic                run;
        logic                div;
        logic [NUM_CNT-1:0]  ien;
        logic [NUM_CNT-1:0]  ovf;
        logic [SEL_W-1:0]    sel0;
        logic [SEL_W-1:0]    sel1;
    } ctrl_t;

    function automatic logic [1:0] slot_addr(input int slot);
        case (slot)
            IX_E0:   return ADDR_E0;
            IX_E1:   return ADDR_E1;
            default: return ADDR_CYC;
        endcase
    endfunction
endpackage

// File: rtl/evt_perf_counter.sv
module evt_perf_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap_o   = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R8
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> (cnt_o == $past(wdata_i)));

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/evt_perf_prescale.sv
module evt_perf_prescale #(
    parameter int LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic div_i,
    input  logic clr_i,
    output logic tick_o
);
    typedef struct packed {
        logic [LOG2-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || !div_i) st_d.phase = '0;
        else if (run_i)      st_d.phase = st_q.phase + 1'b1;
        tick_o = run_i && (!div_i || (&st_q.phase));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    div_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i && run_i && tick_o && !clr_i) |=> (st_q.phase == '0));
endmodule

// File: rtl/evt_perf_unit.sv
module evt_perf_unit
    import evt_perf_pkg::*;
#(
    parameter int         CNT_W     = 32,
    parameter int         EVT_NUM   = 64,
    parameter int         DIV_LOG2  = 6,
    parameter logic [7:0] PARK_CODE = 8'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_NUM-1:0] evt_i,
    input  logic [1:0]         reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic               irq_o
);
    localparam int         IDX_W   = (EVT_NUM > 1) ? $clog2(EVT_NUM) : 1;
    localparam logic [8:0] EVT_LIM = 9'(EVT_NUM);

    ctrl_t              ctrl_d, ctrl_q;
    logic               wr_ctrl, rst_evt, rst_cyc, cyc_tick;
    logic [NUM_CNT-1:0] inc, clr, cwr, wrap, w1c;
    logic [CNT_W-1:0]   cnt [NUM_CNT];

    function automatic logic evt_hit(input logic [SEL_W-1:0] code,
                                     input logic [EVT_NUM-1:0] vec);
        logic legal;
        legal = ({1'b0, code} < EVT_LIM) && (code != PARK_CODE);
        return legal && vec[code[IDX_W-1:0]];
    endfunction

    // control word next state
    always_comb begin
        wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
        rst_evt = wr_ctrl && reg_wdata_i[B_RST_EVT];
        rst_cyc = wr_ctrl && reg_wdata_i[B_RST_CYC];
        w1c     = wr_ctrl ? reg_wdata_i[B_OVF +: NUM_CNT] : '0;
        ctrl_d  = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.run  = reg_wdata_i[B_RUN];
            ctrl_d.div  = reg_wdata_i[B_DIV];
            ctrl_d.ien  = reg_wdata_i[B_IEN +: NUM_CNT];
            ctrl_d.sel0 = reg_wdata_i[B_SEL0 +: SEL_W];
            ctrl_d.sel1 = reg_wdata_i[B_SEL1 +: SEL_W];
        end
        ctrl_d.ovf = (ctrl_q.ovf & ~w1c) | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    evt_perf_prescale #(.LOG2(DIV_LOG2)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ctrl_q.run),
        .div_i  (ctrl_q.div),
        .clr_i  (rst_cyc),
        .tick_o (cyc_tick)
    );

    always_comb begin
        inc[IX_E0]  = ctrl_q.run && evt_hit(ctrl_q.sel0, evt_i);
        inc[IX_E1]  = ctrl_q.run && evt_hit(ctrl_q.sel1, evt_i);
        inc[IX_CYC] = cyc_tick;
        clr[IX_E0]  = rst_evt;
        clr[IX_E1]  = rst_evt;
        clr[IX_CYC] = rst_cyc;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        assign cwr[g] = reg_wr_i && (reg_addr_i == slot_addr(g));

        evt_perf_counter #(.W(CNT_W)) i_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (inc[g]),
            .clr_i   (clr[g]),
            .wr_i    (cwr[g]),
            .wdata_i (reg_wdata_i[CNT_W-1:0]),
            .cnt_o   (cnt[g]),
            .wrap_o  (wrap[g])
        );

        // R9
        ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[g] |=> ctrl_q.ovf[g]);
    end

    // live read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CTRL: begin
                reg_rdata_o[B_RUN]               = ctrl_q.run;
                reg_rdata_o[B_DIV]               = ctrl_q.div;
                reg_rdata_o[B_IEN +: NUM_CNT]    = ctrl_q.ien;
                reg_rdata_o[B_OVF +: NUM_CNT]    = ctrl_q.ovf;
                reg_rdata_o[B_SEL1 +: SEL_W]     = ctrl_q.sel1;
                reg_rdata_o[B_SEL0 +: SEL_W]     = ctrl_q.sel0;
            end
            ADDR_CYC: reg_rdata_o = reg_w_t'(cnt[IX_CYC]);
            ADDR_E0:  reg_rdata_o = reg_w_t'(cnt[IX_E0]);
            default:  reg_rdata_o = reg_w_t'(cnt[IX_E1]);
        endcase
    end

    assign irq_o = |(ctrl_q.ovf & ctrl_q.ien);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ctrl_q.ovf & $past(ctrl_q.ovf & ~w1c)) == $past(ctrl_q.ovf & ~w1c)));

    // R11
    irq_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(wrap & ctrl_q.ien)) && !wr_ctrl) |=> irq_o);

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !cwr[IX_CYC] && !rst_cyc) |=> $stable(cnt[IX_CYC]));
endmodule

// File: tb/test_evt_perf_unit.sv
module test_evt_perf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];
    item_t cur;

    localparam logic [31:0] RUN = 32'h1;

    always #10 clk = ~clk;   // 50 MHz

    evt_perf_unit i_evt_perf_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        sbq.push_back('{0, exp, tag});
        tick();
    endtask

    task automatic irq_chk(input bit exp, input string tag);
        sbq.push_back('{1, {31'b0, exp}, tag});
        tick();
    endtask

    // monitor: compares one expected item per falling edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            logic [31:0] act;
            cur = sbq.pop_front();
            act = cur.is_irq ? {31'b0, irq} : rdata;
            n_run++;
            if (act !== cur.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", cur.tag, act, cur.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        rd(0, 32'h0, "R1 ctrl after reset");
        rd(1, 32'h0, "R1 cycle after reset");
        rd(2, 32'h0, "R1 evt0 after reset");
        rd(3, 32'h0, "R1 evt1 after reset");
        irq_chk(0, "R1 irq after reset");

        // R3: run for ten edges
        wreg(0, RUN);
        repeat (9) tick();
        wreg(0, 32'h0);
        rd(1, 32'd10, "R3 cycle count");
        // R2: stopped counter holds
        repeat (5) tick();
        rd(1, 32'd10, "R2 cycle held while stopped");
        rd(2, 32'd0, "R2 evt0 held");

        // R5: codes 7 and 5
        wreg(0, RUN | (32'h07 << 20) | (32'h05 << 12));
        evt[7] = 1'b1; evt[5] = 1'b1;
        repeat (2) tick();
        evt[5] = 1'b0;
        tick();
        evt = '0;
        wreg(0, (32'h07 << 20) | (32'h05 << 12));
        rd(2, 32'd3, "R5 evt0 code 7");
        rd(3, 32'd2, "R5 evt1 code 5");

        // R6: code 0x20 parks counter 0, code 0x12 counts on counter 1
        wreg(0, RUN | (32'h20 << 20) | (32'h12 << 12));
        evt = '1;
        repeat (4) tick();
        evt = '0;
        wreg(0, (32'h20 << 20) | (32'h12 << 12));
        rd(2, 32'd3, "R6 parked evt0 unchanged");
        rd(3, 32'd6, "R5 evt1 code 0x12");

        // R7
        wreg(0, 32'h2);
        rd(0, 32'h0, "R7 reset bits read zero");
        rd(2, 32'h0, "R7 evt0 cleared");
        rd(3, 32'h0, "R7 evt1 cleared");
        wreg(0, 32'h4);
        rd(1, 32'h0, "R7 cycle cleared");

        // R8: direct write and write priority
        wreg(3, 32'h1234);
        rd(3, 32'h1234, "R8 evt1 load");
        evt[7] = 1'b1;
        wreg(0, RUN | (32'h07 << 20));
        wreg(2, 32'h50);
        evt = '0;
        wreg(0, (32'h07 << 20));
        rd(2, 32'h50, "R8 write beats increment");

        // R9 / R11: cycle counter wrap
        wreg(1, 32'hFFFF_FFFE);
        wreg(0, RUN | 32'h40);
        tick();
        wreg(0, 32'h40);
        rd(1, 32'h0, "R9 cycle wrapped to zero");
        rd(0, 32'h440, "R9 cycle flag set");
        irq_chk(1, "R11 irq from cycle flag");

        // R9: event counter 1 wrap
        wreg(3, 32'hFFFF_FFFF);
        wreg(0, RUN | 32'h40 | (32'h03 << 12));
        evt[3] = 1'b1;
        tick();
        evt = '0;
        wreg(0, 32'h40 | (32'h03 << 12));
        rd(3, 32'h0, "R9 evt1 wrapped");
        rd(0, 32'h3640, "R9 evt1 flag set");

        // R10 / R11
        wreg(0, 32'h440 | (32'h03 << 12));
        rd(0, 32'h3240, "R10 clear one flag keep other");
        irq_chk(0, "R11 irq low without enable");
        wreg(0, 32'h60 | (32'h03 << 12));
        irq_chk(1, "R11 irq on evt1 enable");
        wreg(0, 32'h260 | (32'h03 << 12));
        rd(0, 32'h3060, "R10 evt1 flag cleared");
        irq_chk(0, "R11 irq drops");

        // R10: set wins over same-cycle clear
        wreg(2, 32'hFFFF_FFFF);
        evt[7] = 1'b1;
        wreg(0, RUN | (32'h07 << 20));
        wreg(0, RUN | (32'h07 << 20) | 32'h100);
        evt = '0;
        wreg(0, (32'h07 << 20));
        rd(0, 32'h0070_0100, "R10 wrap beats clear");

        // R4: divide by 64 over 130 run edges
        wreg(0, 32'hD);
        repeat (129) tick();
        wreg(0, 32'h8);
        rd(1, 32'd2, "R4 divided cycle count");
        rd(0, 32'h108, "R4 ctrl after divider run");

        // R12: unused bits ignored
        wreg(0, 32'hF000_0080 | 32'h100);
        rd(0, 32'h0, "R12 unused bits read zero");
        irq_chk(0, "R12 irq idle");

        tick();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule